// File: doc/BRIEF.md
# Fan Start-Up Sequencer with Lockable Mode Register

This block runs the start phase of three PWM fan channels. A start request on an idle channel holds that channel's PWM output at a fixed spin-up drive level. When the spin-up ends, the channel moves to a running state and passes the normal duty input to the output. A stop request returns the channel to idle with the output at zero. Each channel has a per-channel encoded spin-up time. The timeout is counted in ticks from a prescaler that restarts with every spin-up.

Each channel has one mode bit. With the bit clear, only the timeout ends the spin-up. With the bit set, the spin-up also ends early once the tachometer value rises above that channel's minimum, whichever comes first. A small register port holds the mode bits and a control register. The control register has a start bit and a sticky lock bit. The lock freezes the mode bits. While the start bit is clear, the channels behave as if all mode bits were set. Every other address reads as zero and ignores writes.

Top module: `fan_spinup_ctrl`

## Requirements
- R1: After reset, address 75h reads 07h, address 40h reads 00h, every channel is idle with PWM output 0, and no done pulse is present.
- R2: Address 75h holds the mode bits. Bit 0 controls channel 0, bit 1 controls channel 1 and bit 2 controls channel 2. Bits 7:3 always read 0.
- R3: A start request on an idle channel raises `spinning` at the next clock edge. While spinning, the PWM output equals the spin-up drive level (FFh by default). In the running state the PWM output equals the duty input, and in idle it is 0.
- R4: When the effective mode bit is 0, the spin-up lasts exactly (1 << code) * PRESCALE + 1 cycles, where code is the channel's spin-up time input. The tach value does not change this.
- R5: When the effective mode bit is 1 and the tach value is strictly greater than the tach minimum, the spin-up ends at the next edge. A tach value equal to or below the minimum leaves the timeout of R4 in force.
- R6: Bit 1 of the control register at 40h is a lock. Once written to 1, it stays set until reset. While it is set, writes to 75h are ignored.
- R7: While bit 0 (start) of the control register at 40h is 0, every channel acts as if its mode bit were 1, whatever value 75h holds.
- R8: Reads from any address other than 40h and 75h return 00h. Writes to such addresses change neither register.
- R9: When a spin-up ends, `done_pulse` is high for exactly the one cycle in which `spinning` first reads low. `done_by_tach` is 1 if the tach threshold ended the spin-up and 0 if the timeout did, and it holds until the next end.
- R10: A stop request sends a spinning or running channel to idle at the next edge, with no done pulse. A stop request takes priority over a start request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on address) |
| start_req | input | 3 | Per-channel start request |
| stop_req | input | 3 | Per-channel stop request |
| duty_in | input | 24 | Normal duty per channel, 8 bits each |
| tach_val | input | 48 | Tach measurement per channel, 16 bits each |
| tach_min | input | 48 | Tach minimum per channel, 16 bits each |
| spin_code | input | 9 | Encoded spin-up time per channel, 3 bits each |
| pwm_out | output | 24 | PWM level per channel, 8 bits each |
| spinning | output | 1x3 | High while a channel is in spin-up |
| done_pulse | output | 3 | One-cycle pulse when a spin-up ends |
| done_by_tach | output | 3 | Held flag: 1 if the tach threshold ended the last spin-up |

## Verification
The main sweep covers every channel, all eight spin-up codes, both mode bit values, and tach values below, equal to and above the minimum. The equal case separates a strict comparison from an inclusive one. The mode-0 cases with high tach show that the early path is really gated by the mode bit. The duration for each code confirms the shift and the prescale. Separate patterns write a cleared mode with the start bit low, write reserved bits and undefined addresses, and write after the lock. The stop tests abort a spin-up partway and issue start and stop together.

// File: rtl/fan_pkg.sv
package fan_pkg;
  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_SPIN = 2'd1,
    CH_RUN  = 2'd2
  } ch_state_e;

  localparam logic [7:0] MODE_ADDR = 8'h75;
  localparam logic [7:0] CTRL_ADDR = 8'h40;
endpackage

// File: rtl/fan_regs.sv
module fan_regs #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NCH    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NCH-1:0]    mode_q,
  output logic              start_q,
  output logic              lock_q,
  output logic [NCH-1:0]    eff_mode
);
  import fan_pkg::*;

  localparam logic [NCH-1:0] MODE_RST = {NCH{1'b1}};

  logic [NCH-1:0] mode_d;
  logic           start_d, lock_d;
  logic           hit_mode, hit_ctrl;

  assign hit_mode = (addr == ADDR_W'(MODE_ADDR));
  assign hit_ctrl = (addr == ADDR_W'(CTRL_ADDR));

  always_comb begin
    mode_d  = mode_q;
    start_d = start_q;
    lock_d  = lock_q;
    if (wr_en && hit_mode && !lock_q) mode_d = wdata[NCH-1:0];
    if (wr_en && hit_ctrl) begin
      start_d = wdata[0];
      lock_d  = lock_q | wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      start_q <= 1'b0;
      lock_q  <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      start_q <= start_d;
      lock_q  <= lock_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_mode)      rdata[NCH-1:0] = mode_q;
    else if (hit_ctrl) rdata[1:0]     = {lock_q, start_q};
  end

  assign eff_mode = start_q ? mode_q : MODE_RST;
endmodule

// File: rtl/fan_channel.sv
module fan_channel #(
  parameter int          PWM_W     = 8,
  parameter int          TACH_W    = 16,
  parameter int          SUT_W     = 3,
  parameter int          PRESCALE  = 4,
  parameter logic [7:0]  SPIN_DUTY = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_req,
  input  logic              stop_req,
  input  logic              early_en,
  input  logic [PWM_W-1:0]  duty,
  input  logic [TACH_W-1:0] tach,
  input  logic [TACH_W-1:0] tach_lim,
  input  logic [SUT_W-1:0]  sut_code,
  output logic [PWM_W-1:0]  pwm,
  output logic              spinning,
  output logic              done_pulse,
  output logic              done_by_tach
);
  import fan_pkg::*;

  localparam int CNT_W = 2 ** SUT_W;
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  ch_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic [PRE_W-1:0] pre_q, pre_d;
  logic             done_d, flag_d;
  logic             tach_hit, time_hit;

  assign limit    = CNT_W'(1) << sut_code;
  assign tach_hit = early_en && (tach > tach_lim);
  assign time_hit = (cnt_q >= limit);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    done_d  = 1'b0;
    flag_d  = done_by_tach;
    case (state_q)
      CH_IDLE: begin
        if (start_req && !stop_req) begin
          state_d = CH_SPIN;
          cnt_d   = '0;
          pre_d   = '0;
        end
      end
      CH_SPIN: begin
        if (stop_req) begin
          state_d = CH_IDLE;
        end else if (tach_hit) begin
          state_d = CH_RUN;
          done_d  = 1'b1;
          flag_d  = 1'b1;
        end else if (time_hit) begin
          state_d = CH_RUN;
          done_d  = 1'b1;
          flag_d  = 1'b0;
        end else if (pre_q == PRE_LAST) begin
          pre_d = '0;
          cnt_d = cnt_q + CNT_W'(1);
        end else begin
          pre_d = pre_q + PRE_W'(1);
        end
      end
      CH_RUN: begin
        if (stop_req) state_d = CH_IDLE;
      end
      default: state_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= CH_IDLE;
      cnt_q        <= '0;
      pre_q        <= '0;
      done_pulse   <= 1'b0;
      done_by_tach <= 1'b0;
    end else begin
      state_q      <= state_d;
      cnt_q        <= cnt_d;
      pre_q        <= pre_d;
      done_pulse   <= done_d;
      done_by_tach <= flag_d;
    end
  end

  always_comb begin
    case (state_q)
      CH_SPIN: pwm = PWM_W'(SPIN_DUTY);
      CH_RUN:  pwm = duty;
      default: pwm = '0;
    endcase
  end

  assign spinning = (state_q == CH_SPIN);
endmodule

// File: rtl/fan_spinup_ctrl.sv
module fan_spinup_ctrl #(
  parameter int         NCH       = 3,
  parameter int         PWM_W     = 8,
  parameter int         TACH_W    = 16,
  parameter int         SUT_W     = 3,
  parameter int         PRESCALE  = 4,
  parameter logic [7:0] SPIN_DUTY = 8'hFF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [7:0]            reg_addr,
  input  logic [7:0]            reg_wdata,
  output logic [7:0]            reg_rdata,
  input  logic [NCH-1:0]        start_req,
  input  logic [NCH-1:0]        stop_req,
  input  logic [NCH*PWM_W-1:0]  duty_in,
  input  logic [NCH*TACH_W-1:0] tach_val,
  input  logic [NCH*TACH_W-1:0] tach_min,
  input  logic [NCH*SUT_W-1:0]  spin_code,
  output logic [NCH*PWM_W-1:0]  pwm_out,
  output logic [NCH-1:0]        spinning,
  output logic [NCH-1:0]        done_pulse,
  output logic [NCH-1:0]        done_by_tach
);
  logic [1:0]     rst_sync;
  logic           rst_sync_n;
  logic [NCH-1:0] mode_q, eff_mode;
  logic           start_q, lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  fan_regs #(.ADDR_W(8), .DATA_W(8), .NCH(NCH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (reg_wr),
    .addr    (reg_addr),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .mode_q  (mode_q),
    .start_q (start_q),
    .lock_q  (lock_q),
    .eff_mode(eff_mode)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    fan_channel #(
      .PWM_W(PWM_W), .TACH_W(TACH_W), .SUT_W(SUT_W),
      .PRESCALE(PRESCALE), .SPIN_DUTY(SPIN_DUTY)
    ) u_ch (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .start_req   (start_req[i]),
      .stop_req    (stop_req[i]),
      .early_en    (eff_mode[i]),
      .duty        (duty_in[i*PWM_W +: PWM_W]),
      .tach        (tach_val[i*TACH_W +: TACH_W]),
      .tach_lim    (tach_min[i*TACH_W +: TACH_W]),
      .sut_code    (spin_code[i*SUT_W +: SUT_W]),
      .pwm         (pwm_out[i*PWM_W +: PWM_W]),
      .spinning    (spinning[i]),
      .done_pulse  (done_pulse[i]),
      .done_by_tach(done_by_tach[i])
    );
  end
endmodule

// File: rtl/fan_spinup_chk.sv
module fan_spinup_chk #(
  parameter int         NCH       = 3,
  parameter int         PWM_W     = 8,
  parameter logic [7:0] SPIN_DUTY = 8'hFF
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           reg_addr,
  input logic [7:0]           reg_rdata,
  input logic [NCH*PWM_W-1:0] pwm_out,
  input logic [NCH-1:0]       spinning,
  input logic [NCH-1:0]       done_pulse,
  input logic [NCH-1:0]       done_by_tach,
  input logic [NCH-1:0]       mode_q,
  input logic [NCH-1:0]       eff_mode,
  input logic                 lock_q
);
  import fan_pkg::*;

  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q); // R6

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(mode_q)); // R6

  AST_UNDEF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != MODE_ADDR && reg_addr != CTRL_ADDR) |-> (reg_rdata == 8'h00)); // R8

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == MODE_ADDR) |-> (reg_rdata[7:3] == 5'd0)); // R2

  for (genvar i = 0; i < NCH; i++) begin : g_a
    AST_SPIN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      spinning[i] |-> (pwm_out[i*PWM_W +: PWM_W] == PWM_W'(SPIN_DUTY))); // R3

    AST_DONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse[i] |-> ($past(spinning[i]) && !spinning[i])); // R9

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_pulse[i] |=> !done_pulse[i]); // R9

    AST_TACH_NEEDS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      (done_pulse[i] && done_by_tach[i]) |-> $past(eff_mode[i])); // R5
  end
endmodule

bind fan_spinup_ctrl fan_spinup_chk #(
  .NCH(NCH), .PWM_W(PWM_W), .SPIN_DUTY(SPIN_DUTY)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .reg_addr    (reg_addr),
  .reg_rdata   (reg_rdata),
  .pwm_out     (pwm_out),
  .spinning    (spinning),
  .done_pulse  (done_pulse),
  .done_by_tach(done_by_tach),
  .mode_q      (mode_q),
  .eff_mode    (eff_mode),
  .lock_q      (lock_q)
);

// File: tb/tb_fan_spinup_ctrl.sv
module tb_fan_spinup_ctrl;
  localparam int NCH = 3, PWM_W = 8, TACH_W = 16, SUT_W = 3, PRE = 4;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  reg_wr;
  logic [7:0]            reg_addr, reg_wdata, reg_rdata;
  logic [NCH-1:0]        start_req, stop_req;
  logic [NCH*PWM_W-1:0]  duty_in, pwm_out;
  logic [NCH*TACH_W-1:0] tach_val, tach_min;
  logic [NCH*SUT_W-1:0]  spin_code;
  logic [NCH-1:0]        spinning, done_pulse, done_by_tach;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  fan_spinup_ctrl #(.NCH(NCH), .PWM_W(PWM_W), .TACH_W(TACH_W), .SUT_W(SUT_W),
                    .PRESCALE(PRE)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_req(start_req),
    .stop_req(stop_req), .duty_in(duty_in), .tach_val(tach_val),
    .tach_min(tach_min), .spin_code(spin_code), .pwm_out(pwm_out),
    .spinning(spinning), .done_pulse(done_pulse), .done_by_tach(done_by_tach)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // Starts channel ch, measures spin-up length, checks done pulse and flag
  task automatic run_spin(input int ch, input int exp_len, input bit exp_tach,
                          input string tag);
    int len = 0;
    bit pwm_ok = 1;
    @(negedge clk);
    start_req[ch] = 1'b1;
    @(negedge clk);
    start_req[ch] = 1'b0;
    chk(spinning[ch] == 1'b1, {tag, " R3 spin entry"}, spinning[ch], 1);
    while (spinning[ch] && len < 2000) begin
      if (pwm_out[ch*PWM_W +: PWM_W] != 8'hFF) pwm_ok = 0;
      chk(done_pulse[ch] == 1'b0, {tag, " R9 no early done"}, done_pulse[ch], 0);
      len++;
      @(negedge clk);
    end
    chk(pwm_ok, {tag, " R3 spin level"}, pwm_ok, 1);
    chk(len == exp_len, {tag, " R4/R5 spin length"}, len, exp_len);
    chk(done_pulse[ch] == 1'b1, {tag, " R9 done pulse"}, done_pulse[ch], 1);
    chk(done_by_tach[ch] == exp_tach, {tag, " R9 end flag"}, done_by_tach[ch], exp_tach);
    chk(pwm_out[ch*PWM_W +: PWM_W] == 8'(8'h40 + ch), {tag, " R3 run duty"},
        pwm_out[ch*PWM_W +: PWM_W], 8'h40 + ch);
    @(negedge clk);
    chk(done_pulse[ch] == 1'b0, {tag, " R9 pulse width"}, done_pulse[ch], 0);
    chk(done_by_tach[ch] == exp_tach, {tag, " R9 flag held"}, done_by_tach[ch], exp_tach);
    stop_req[ch] = 1'b1;
    @(negedge clk);
    stop_req[ch] = 1'b0;
    chk(pwm_out[ch*PWM_W +: PWM_W] == 8'h00, {tag, " R10 stop from run"},
        pwm_out[ch*PWM_W +: PWM_W], 0);
  endtask

  task automatic set_tach(input int ch, input int kind);
    tach_min[ch*TACH_W +: TACH_W] = 16'd200;
    case (kind)
      0:       tach_val[ch*TACH_W +: TACH_W] = 16'd100;
      1:       tach_val[ch*TACH_W +: TACH_W] = 16'd200;
      default: tach_val[ch*TACH_W +: TACH_W] = 16'd300;
    endcase
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      summary();
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    start_req = 0; stop_req = 0;
    tach_val = 0; tach_min = 0; spin_code = 0;
    for (int i = 0; i < NCH; i++) duty_in[i*PWM_W +: PWM_W] = 8'(8'h40 + i);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    rd(8'h75, d); chk(d == 8'h07, "R1 mode reset", d, 8'h07);
    rd(8'h40, d); chk(d == 8'h00, "R1 ctrl reset", d, 8'h00);
    chk(pwm_out == '0, "R1 pwm idle", int'(pwm_out != 0), 0);
    chk(spinning == '0 && done_pulse == '0, "R1 idle no done", spinning, 0);

    // R2 reserved bits read as zero
    wr(8'h75, 8'hFA);
    rd(8'h75, d); chk(d == 8'h02, "R2 reserved masked", d, 8'h02);

    // R8 undefined addresses
    for (int a = 0; a < 256; a += 17) begin
      if (a != 8'h75 && a != 8'h40) begin
        wr(8'(a), 8'hFF);
        rd(8'(a), d); chk(d == 8'h00, "R8 undefined read", d, 0);
      end
    end
    rd(8'h75, d); chk(d == 8'h02, "R8 mode untouched", d, 8'h02);
    rd(8'h40, d); chk(d == 8'h00, "R8 ctrl untouched", d, 8'h00);

    // R7 start bit clear forces early mode: mode reg 0, tach high
    wr(8'h75, 8'h00);
    set_tach(0, 2);
    spin_code[0 +: SUT_W] = 3'd2;
    run_spin(0, 1, 1'b1, "R7 default mode");

    // Main sweep with start bit set
    wr(8'h40, 8'h01);
    for (int ch = 0; ch < NCH; ch++) begin
      for (int code = 0; code < 8; code++) begin
        for (int m = 0; m < 2; m++) begin
          for (int k = 0; k < 3; k++) begin
            int exp_len;
            bit early;
            wr(8'h75, 8'(3'b111 & ~(3'(!m) << ch)));
            set_tach(ch, k);
            spin_code[ch*SUT_W +: SUT_W] = 3'(code);
            early = (m == 1) && (k == 2);
            exp_len = early ? 1 : (1 << code) * PRE + 1;
            run_spin(ch, exp_len, early, m ? "R5 sweep" : "R4 sweep");
          end
        end
      end
    end

    // R10 stop during spin-up: no done pulse
    set_tach(1, 0);
    spin_code[SUT_W +: SUT_W] = 3'd5;
    @(negedge clk); start_req[1] = 1'b1;
    @(negedge clk); start_req[1] = 1'b0;
    repeat (10) @(negedge clk);
    stop_req[1] = 1'b1;
    @(negedge clk); stop_req[1] = 1'b0;
    chk(spinning[1] == 1'b0, "R10 abort spin", spinning[1], 0);
    chk(done_pulse[1] == 1'b0, "R10 abort no done", done_pulse[1], 0);
    chk(pwm_out[PWM_W +: PWM_W] == 8'h00, "R10 abort pwm", pwm_out[PWM_W +: PWM_W], 0);
    // R10 stop priority over start
    @(negedge clk); start_req[2] = 1'b1; stop_req[2] = 1'b1;
    @(negedge clk); start_req[2] = 1'b0; stop_req[2] = 1'b0;
    chk(spinning[2] == 1'b0, "R10 stop priority", spinning[2], 0);

    // R6 lock
    wr(8'h75, 8'h05);
    wr(8'h40, 8'h03);
    wr(8'h75, 8'h02);
    rd(8'h75, d); chk(d == 8'h05, "R6 locked write ignored", d, 8'h05);
    wr(8'h40, 8'h01);
    rd(8'h40, d); chk(d == 8'h03, "R6 lock sticky", d, 8'h03);
    // locked mode still effective: channel 1 bit is 0 => timeout with tach high
    set_tach(1, 2);
    spin_code[SUT_W +: SUT_W] = 3'd1;
    run_spin(1, 2 * PRE + 1, 1'b0, "R6 locked mode in force");

    finished = 1;
    summary();
    $finish;
  end
endmodule